// File: doc/BRIEF.md
# Two-Channel Output Control and Supply Status Register

This block holds one status byte that controls two open-drain output channels and reports whether external supply power is present. Two of its bits are channel flip-flops. Each flip-flop drives an active-low transistor enable, so a stored 0 switches that channel on and a stored 1 switches it off. One bit is a read-only flag that follows the supply-present input live. The remaining low bits are ordinary storage.

A two-state sequencer governs start-up. While reset is asserted the sequencer sits in `ST_HOLD`. In that state both outputs are forced off, and any write is ignored. On the first clock edge after reset is released, the sequencer copies the stored power-on value into the register and takes the transition `HOLD_TO_RUN` into `ST_RUN`. It then stays in `ST_RUN`, through the transition `RUN_STAY`, until the next reset.

In `ST_RUN` the register is updated through two paths. A byte-wide status write updates every bit except the supply flag. A separate channel-access write updates only the two channel flip-flops. If both writes arrive in the same cycle, the channel-access write decides the two channel bits, and the byte write still sets the other bits.

Top module: `pio_status_reg`

## Requirements
- R1: While reset is asserted, and in the `ST_HOLD` cycle that follows its release, `chan_drv_n` is 2'b11, meaning both channels are off.
- R2: On the first clock edge after reset is released, bits 6:0 of `por_value` are loaded into the register. The load is visible on `st_rd_data` after that edge.
- R3: In `ST_RUN`, a byte write (`st_wr_en`=1) with no channel-access write in the same cycle sets bits 6:0 of `st_rd_data` to bits 6:0 of `st_wr_data` after the next edge.
- R4: Bit 7 of `st_rd_data` always equals `supply_ok` in the same cycle. Writes to bit 7 through a byte write or the power-on load have no effect on it.
- R5: In `ST_RUN`, `chan_drv_n[0]` equals stored bit 5 (channel A) and `chan_drv_n[1]` equals stored bit 6 (channel B). A value of 0 means the channel is on.
- R6: A channel-access write (`ch_wr_en`=1) in `ST_RUN` sets bit 5 to `ch_wr_val[0]` and bit 6 to `ch_wr_val[1]`, and leaves bits 4:0 unchanged.
- R7: When a byte write and a channel-access write occur in the same cycle, bits 6:5 take the value from `ch_wr_val`, and bits 4:0 take the value from `st_wr_data`.
- R8: Writes presented during the `ST_HOLD` cycle are ignored, because the power-on load takes precedence. The sequencer is in `ST_RUN` after that cycle.
- R9: While reset is asserted, the stored value reads as bits 6:5 = 1 and bits 4:0 = 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| st_wr_en | input | 1 | Byte write strobe for the status byte |
| st_wr_data | input | 8 | Byte write data |
| ch_wr_en | input | 1 | Channel-access write strobe |
| ch_wr_val | input | 2 | Channel-access value, bit 0 for channel A and bit 1 for channel B |
| por_value | input | 8 | Stored power-on value |
| supply_ok | input | 1 | High when external supply power is present |
| st_rd_data | output | 8 | Status byte read value |
| chan_drv_n | output | 2 | Active-low transistor enables, bit 0 for A and bit 1 for B |

## Verification
The bench builds the block with its default parameters. With these defaults the byte is 8 bits wide, the channel flip-flops sit at bits 5 and 6, and the supply flag sits at bit 7. Because the two channel bits are adjacent and sit just below the read-only flag, a single byte pattern can exercise the channel masking, the blocking of the supply bit, and the plain storage bits together. The same defaults also allow a simultaneous byte write and channel-access write to be checked bit by bit.

// File: rtl/pio_stat_pkg.sv
package pio_stat_pkg;
    typedef enum logic [0:0] {
        ST_HOLD = 1'b0,
        ST_RUN  = 1'b1
    } pio_state_e;

    localparam int NUM_CH = 2;
endpackage

// File: rtl/pio_seq.sv
module pio_seq
    import pio_stat_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    output logic load_en,
    output logic acc_en
);
    pio_state_e state_q;
    pio_state_e state_d;

    // Next-state logic: HOLD_TO_RUN and RUN_STAY
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_HOLD: state_d = ST_RUN;
            ST_RUN:  state_d = ST_RUN;
            default: state_d = ST_HOLD;
        endcase
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_HOLD;
        else        state_q <= state_d;
    end

    // Outputs decoded from the current state
    always_comb begin
        load_en = 1'b0;
        acc_en  = 1'b0;
        unique case (state_q)
            ST_HOLD: load_en = 1'b1;
            ST_RUN:  acc_en  = 1'b1;
            default: load_en = 1'b1;
        endcase
    end
endmodule

// File: rtl/pio_reg.sv
module pio_reg #(
    parameter int           W       = 8,
    parameter int           A_BIT   = 5,
    parameter int           B_BIT   = 6,
    parameter int           SUP_BIT = 7,
    parameter logic [W-1:0] RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load_en,
    input  logic         acc_en,
    input  logic         byte_we,
    input  logic [W-1:0] byte_d,
    input  logic         ch_we,
    input  logic [1:0]   ch_d,
    input  logic [W-1:0] por_d,
    output logic [W-1:0] q
);
    for (genvar i = 0; i < W; i++) begin : g_bit
        if (i == SUP_BIT) begin : g_ro
            // The supply flag is never stored here.
            assign q[i] = 1'b0;
        end else begin : g_rw
            logic bit_q;
            logic bit_d;
            always_comb begin
                bit_d = bit_q;
                if (load_en) begin
                    bit_d = por_d[i];
                end else if (acc_en) begin
                    if (byte_we) bit_d = byte_d[i];
                    // The channel-access path overrides the byte write
                    if (ch_we && (i == A_BIT)) bit_d = ch_d[0];
                    if (ch_we && (i == B_BIT)) bit_d = ch_d[1];
                end
            end
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) bit_q <= RST_VAL[i];
                else        bit_q <= bit_d;
            end
            assign q[i] = bit_q;
        end
    end
endmodule

// File: rtl/pio_drv.sv
module pio_drv #(
    parameter int W       = 8,
    parameter int A_BIT   = 5,
    parameter int B_BIT   = 6,
    parameter int SUP_BIT = 7
) (
    input  logic         hold,
    input  logic [W-1:0] q,
    input  logic         supply_ok,
    output logic [1:0]   chan_n,
    output logic [W-1:0] rd
);
    always_comb begin
        if (hold) chan_n = 2'b11;
        else      chan_n = {q[B_BIT], q[A_BIT]};
    end

    always_comb begin
        rd          = q;
        rd[SUP_BIT] = supply_ok;
    end
endmodule

// File: rtl/pio_status_reg.sv
module pio_status_reg #(
    parameter int W       = 8,
    parameter int A_BIT   = 5,
    parameter int B_BIT   = 6,
    parameter int SUP_BIT = 7
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         st_wr_en,
    input  logic [W-1:0] st_wr_data,
    input  logic         ch_wr_en,
    input  logic [1:0]   ch_wr_val,
    input  logic [W-1:0] por_value,
    input  logic         supply_ok,
    output logic [W-1:0] st_rd_data,
    output logic [1:0]   chan_drv_n
);
    localparam logic [W-1:0] RST_VAL = (W'(1) << A_BIT) | (W'(1) << B_BIT);

    logic         seq_hold;
    logic         seq_run;
    logic [W-1:0] reg_q;

    pio_seq u_seq (
        .clk     (clk),
        .rst_n   (rst_n),
        .load_en (seq_hold),
        .acc_en  (seq_run)
    );

    pio_reg #(
        .W       (W),
        .A_BIT   (A_BIT),
        .B_BIT   (B_BIT),
        .SUP_BIT (SUP_BIT),
        .RST_VAL (RST_VAL)
    ) u_reg (
        .clk     (clk),
        .rst_n   (rst_n),
        .load_en (seq_hold),
        .acc_en  (seq_run),
        .byte_we (st_wr_en),
        .byte_d  (st_wr_data),
        .ch_we   (ch_wr_en),
        .ch_d    (ch_wr_val),
        .por_d   (por_value),
        .q       (reg_q)
    );

    pio_drv #(
        .W       (W),
        .A_BIT   (A_BIT),
        .B_BIT   (B_BIT),
        .SUP_BIT (SUP_BIT)
    ) u_drv (
        .hold      (seq_hold),
        .q         (reg_q),
        .supply_ok (supply_ok),
        .chan_n    (chan_drv_n),
        .rd        (st_rd_data)
    );
endmodule

// File: rtl/pio_status_chk.sv
module pio_status_chk #(
    parameter int W       = 8,
    parameter int A_BIT   = 5,
    parameter int B_BIT   = 6,
    parameter int SUP_BIT = 7
) (
    input logic         clk,
    input logic         rst_n,
    input logic         hold,
    input logic         st_wr_en,
    input logic [W-1:0] st_wr_data,
    input logic         ch_wr_en,
    input logic [1:0]   ch_wr_val,
    input logic [W-1:0] por_value,
    input logic [W-1:0] st_rd_data,
    input logic [1:0]   chan_drv_n
);
    localparam logic [W-1:0] KEEP = ~(W'(1) << SUP_BIT);

    p_hold_off_r1: assert property (@(posedge clk) disable iff (!rst_n)
        hold |-> chan_drv_n == 2'b11);

    p_por_load_r2: assert property (@(posedge clk) disable iff (!rst_n)
        hold |=> (st_rd_data & KEEP) == ($past(por_value) & KEEP));

    p_byte_wr_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (!hold && st_wr_en && !ch_wr_en) |=>
            (st_rd_data & KEEP) == ($past(st_wr_data) & KEEP));

    p_chan_map_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !hold |-> chan_drv_n == {st_rd_data[B_BIT], st_rd_data[A_BIT]});

    p_chan_acc_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (!hold && ch_wr_en) |=>
            {st_rd_data[B_BIT], st_rd_data[A_BIT]} == $past(ch_wr_val));

    p_leave_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
        hold |=> !hold);
endmodule

bind pio_status_reg pio_status_chk #(
    .W       (W),
    .A_BIT   (A_BIT),
    .B_BIT   (B_BIT),
    .SUP_BIT (SUP_BIT)
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .hold       (seq_hold),
    .st_wr_en   (st_wr_en),
    .st_wr_data (st_wr_data),
    .ch_wr_en   (ch_wr_en),
    .ch_wr_val  (ch_wr_val),
    .por_value  (por_value),
    .st_rd_data (st_rd_data),
    .chan_drv_n (chan_drv_n)
);

// File: tb/tb_pio_status_reg.sv
module tb_pio_status_reg;
    logic       clk = 1'b0;
    logic       rst_n;
    logic       st_wr_en;
    logic [7:0] st_wr_data;
    logic       ch_wr_en;
    logic [1:0] ch_wr_val;
    logic [7:0] por_value;
    logic       supply_ok;
    logic [7:0] st_rd_data;
    logic [1:0] chan_drv_n;

    int n_chk  = 0;
    int n_fail = 0;
    bit done   = 1'b0;

    always #4 clk = ~clk;

    pio_status_reg dut (
        .clk        (clk),
        .rst_n      (rst_n),
        .st_wr_en   (st_wr_en),
        .st_wr_data (st_wr_data),
        .ch_wr_en   (ch_wr_en),
        .ch_wr_val  (ch_wr_val),
        .por_value  (por_value),
        .supply_ok  (supply_ok),
        .st_rd_data (st_rd_data),
        .chan_drv_n (chan_drv_n)
    );

    typedef struct packed {
        logic       we;
        logic [7:0] wd;
        logic       ce;
        logic [1:0] cv;
        logic       sup;
        logic [7:0] exp_rd;
        logic [1:0] exp_ch;
    } vec_t;

    // Applied in order after a power-on load of 8'h9A
    localparam vec_t VECS [6] = '{
        '{1'b1, 8'hFF, 1'b0, 2'b00, 1'b0, 8'h7F, 2'b11}, // R3 R4: bit 7 write blocked
        '{1'b0, 8'h00, 1'b1, 2'b01, 1'b1, 8'hBF, 2'b01}, // R6 R5
        '{1'b1, 8'h20, 1'b1, 2'b10, 1'b0, 8'h40, 2'b10}, // R7 collision
        '{1'b0, 8'h00, 1'b0, 2'b00, 1'b1, 8'hC0, 2'b10}, // R4 live flag
        '{1'b1, 8'h55, 1'b0, 2'b00, 1'b0, 8'h55, 2'b10}, // R3 R5
        '{1'b0, 8'h00, 1'b1, 2'b00, 1'b1, 8'h95, 2'b00}  // R6 bits 4:0 kept
    };

    task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic idle_inputs();
        st_wr_en   = 1'b0;
        st_wr_data = 8'h00;
        ch_wr_en   = 1'b0;
        ch_wr_val  = 2'b00;
    endtask

    initial begin
        #(8 * 5000);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        rst_n     = 1'b0;
        por_value = 8'h9A;
        supply_ok = 1'b1;
        idle_inputs();
        repeat (3) @(posedge clk);
        @(negedge clk);
        chk("R9 reset value", st_rd_data, 8'hE0);
        chk("R1 off in reset", {6'd0, chan_drv_n}, 8'h03);
        supply_ok = 1'b0;
        #1;
        chk("R4 flag follows supply", st_rd_data, 8'h60);

        // Release reset with writes that must be ignored in the hold cycle
        rst_n      = 1'b1;
        supply_ok  = 1'b1;
        st_wr_en   = 1'b1;
        st_wr_data = 8'h00;
        ch_wr_en   = 1'b1;
        ch_wr_val  = 2'b11;
        #1;
        chk("R1 off in hold cycle", {6'd0, chan_drv_n}, 8'h03);
        @(negedge clk);
        chk("R2 R8 power-on load", st_rd_data, 8'h9A);
        chk("R5 channels follow load", {6'd0, chan_drv_n}, 8'h00);

        for (int i = 0; i < 6; i++) begin
            st_wr_en   = VECS[i].we;
            st_wr_data = VECS[i].wd;
            ch_wr_en   = VECS[i].ce;
            ch_wr_val  = VECS[i].cv;
            supply_ok  = VECS[i].sup;
            @(negedge clk);
            chk($sformatf("R3-vector %0d read", i), st_rd_data, VECS[i].exp_rd);
            chk($sformatf("R5 vector %0d chan", i), {6'd0, chan_drv_n}, {6'd0, VECS[i].exp_ch});
        end
        idle_inputs();

        // Reset in mid-run: outputs go off at once, then a new load
        rst_n     = 1'b0;
        por_value = 8'h7F;
        supply_ok = 1'b1;
        #1;
        chk("R1 off on async reset", {6'd0, chan_drv_n}, 8'h03);
        chk("R9 reset value again", st_rd_data, 8'hE0);
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R2 second load", st_rd_data, 8'hFF);
        chk("R5 both off after load", {6'd0, chan_drv_n}, 8'h03);

        // Collision: channels turned on while byte write sets low bits
        st_wr_en   = 1'b1;
        st_wr_data = 8'h6A;
        ch_wr_en   = 1'b1;
        ch_wr_val  = 2'b00;
        supply_ok  = 1'b0;
        @(negedge clk);
        chk("R7 channel access wins", st_rd_data, 8'h0A);
        chk("R7 both channels on", {6'd0, chan_drv_n}, 8'h00);
        idle_inputs();

        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
        $finish;
    end
endmodule